// File: doc/BRIEF.md
# Programmable Chip Select Address Decoder

This block sits at the start of the external bus path. On every bus cycle it compares the upper half of the cycle address with seven programmable chip-select windows. It also folds in the match results of two DRAM block windows, which another block computes. From these it decides which select lines to drive and what kind of access the cycle is. It reports the port width and whether bursting is inhibited. It also reports whether the cycle must be terminated externally and whether the match pattern is undefined.

Each window has a base value, a mask with a valid bit, and a control word. Software loads them through a simple write port, one field per write. After reset, window 0 answers every address so that a boot memory can be fetched before any window is configured. The decoded result is registered when a cycle starts and is held until the cycle ends.

Top module: `csdec_top`

## Requirements
- R1: A window hits when it is enabled and, for every address bit 31:16 whose mask bit is 0, the address bit equals the base bit. Mask bits set to 1 are ignored, and a window whose valid bit is 0 never hits (window 0 while in boot mode excepted, see R7).
- R2: With no window hit and no DRAM match, every cs_n is high, dram_sel is 0, port_size is 00 (32-bit), burst_inh is 1, ext_term is 1 and undef_acc is 0.
- R3: With exactly one window hit and no DRAM match, only that line of cs_n is low. port_size comes from the window's control code: code 00 gives 00 (32-bit), code 01 gives 01 (8-bit), code 10 or 11 gives 10 (16-bit). burst_inh is the inverse of the window's burst-enable bit, and ext_term is 0.
- R4: With two or more window hits and no DRAM match, every hit line of cs_n is low, port_size is 00, burst_inh is 1 and ext_term is 1.
- R5: With exactly one DRAM match and no window hit, the matching dram_sel bit is 1, every cs_n is high, port_size is 00, burst_inh is 0, ext_term is 0 and undef_acc is 0.
- R6: A DRAM match together with any other match (the second DRAM window or any chip-select window) sets undef_acc to 1. In that case every cs_n is high, dram_sel is 0, port_size is 00, burst_inh is 1 and ext_term is 1.
- R7: From reset, window 0 hits every address. It stays in this mode until window 0's mask field is written with valid bit 1; a mask write with valid bit 0 leaves it in boot mode.
- R8: Outputs take the decoded result at the clock edge where cyc_start is sampled 1, and hold it while cyc_start and cyc_end are 0. At an edge with cyc_end 1 and cyc_start 0 they return to the idle state of R10. When both are 1, the start wins.
- R9: The write port stores reg_wdata at the edge where reg_we is 1, into window reg_idx. reg_field selects the field: 0 stores the base from bits 15:0; 1 stores the mask from bits 15:0 and the valid bit from bit 16; 2 stores the control code from bits 1:0 and burst enable from bit 2.
- R10: After reset, every cs_n is high, dram_sel is 0, port_size is 00, and burst_inh, ext_term and undef_acc are 0. All windows reset to base 0, mask 0, invalid, control code 00, burst disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_we | input | 1 | Register write strobe |
| reg_idx | input | 3 | Window number to write |
| reg_field | input | 2 | Field select: 0 base, 1 mask and valid, 2 control |
| reg_wdata | input | 17 | Write data |
| cyc_start | input | 1 | Bus cycle begins; address and DRAM matches are valid |
| cyc_end | input | 1 | Bus cycle finishes |
| addr | input | 32 | Bus cycle address |
| dram_hit | input | 2 | Match result of each DRAM block window |
| cs_n | output | 7 | Chip select lines, active low |
| dram_sel | output | 2 | DRAM block select, active high |
| port_size | output | 2 | 00 32-bit, 01 8-bit, 10 16-bit |
| burst_inh | output | 1 | Burst inhibited for this cycle |
| ext_term | output | 1 | Cycle terminated externally |
| undef_acc | output | 1 | Undefined match combination |

## Verification
The bench loads six overlapping windows and one disabled window. It then sweeps the upper address across the first 2K values in steps of 8, under all four DRAM match patterns. This separates the no-hit, single-hit, multi-hit, DRAM-only and undefined cases, as well as the mask and valid behaviour. A few far addresses show that unmasked high bits still count. Before the windows are loaded, scattered addresses show whether boot mode survives a mask write with valid 0 and ends on one with valid 1. Separate cycles tell apart hold, release, and start-over-end ordering.

// File: rtl/csdec_pkg.sv
package csdec_pkg;

  localparam int CMP_W = 16;

  typedef enum logic [1:0] {
    PS_32 = 2'b00,
    PS_8  = 2'b01,
    PS_16 = 2'b10
  } port_sz_e;

  typedef enum logic [1:0] {
    FLD_BASE = 2'd0,
    FLD_MASK = 2'd1,
    FLD_CTRL = 2'd2,
    FLD_NONE = 2'd3
  } reg_fld_e;

  typedef enum logic [2:0] {
    ACC_EXT,
    ACC_CS,
    ACC_MULTI,
    ACC_DRAM,
    ACC_UNDEF
  } acc_kind_e;

  typedef struct packed {
    logic [CMP_W-1:0] base;
    logic [CMP_W-1:0] mask;
    logic             valid;
    logic [1:0]       ps_code;
    logic             burst_en;
  } win_cfg_t;

  // Masked compare: bits with mask 1 are don't-care.
  function automatic logic win_hit(input logic [CMP_W-1:0] a,
                                   input logic [CMP_W-1:0] base,
                                   input logic [CMP_W-1:0] mask,
                                   input logic             en);
    return en && (((a ^ base) & ~mask) == '0);
  endfunction

  function automatic port_sz_e ps_decode(input logic [1:0] code);
    case (code)
      2'b00:   return PS_32;
      2'b01:   return PS_8;
      default: return PS_16;
    endcase
  endfunction

endpackage

// File: rtl/csdec_regs.sv
module csdec_regs
  import csdec_pkg::*;
#(
  parameter int NUM_CS = 7,
  parameter int IDX_W  = $clog2(NUM_CS)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    reg_we,
  input  logic [IDX_W-1:0]        reg_idx,
  input  logic [1:0]              reg_field,
  input  logic [CMP_W:0]          reg_wdata,
  output win_cfg_t [NUM_CS-1:0]   cfg,
  output logic                    boot_global
);

  logic boot_clear;
  assign boot_clear = reg_we && (reg_idx == '0) && (reg_field == FLD_MASK)
                      && reg_wdata[CMP_W];

  for (genvar i = 0; i < NUM_CS; i++) begin : g_win
    logic sel;
    assign sel = reg_we && (reg_idx == IDX_W'(i));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cfg[i] <= '0;
      end else if (sel) begin
        case (reg_field)
          FLD_BASE: cfg[i].base <= reg_wdata[CMP_W-1:0];
          FLD_MASK: begin
            cfg[i].mask  <= reg_wdata[CMP_W-1:0];
            cfg[i].valid <= reg_wdata[CMP_W];
          end
          FLD_CTRL: begin
            cfg[i].ps_code  <= reg_wdata[1:0];
            cfg[i].burst_en <= reg_wdata[2];
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          boot_global <= 1'b1;
    else if (boot_clear) boot_global <= 1'b0;
  end

  p_boot_exit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(boot_global) |-> $past(reg_we && reg_idx == '0 &&
                                 reg_field == FLD_MASK && reg_wdata[CMP_W]));

  p_boot_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !boot_global |=> !boot_global);

endmodule

// File: rtl/csdec_window.sv
module csdec_window
  import csdec_pkg::*;
(
  input  logic [CMP_W-1:0] a_hi,
  input  win_cfg_t         cfg,
  input  logic             force_hit,
  output logic             hit
);

  logic cmp_hit;
  assign cmp_hit = win_hit(a_hi, cfg.base, cfg.mask, cfg.valid);
  assign hit     = cmp_hit || force_hit;

endmodule

// File: rtl/csdec_resolve.sv
module csdec_resolve
  import csdec_pkg::*;
#(
  parameter int NUM_CS   = 7,
  parameter int NUM_DRAM = 2
) (
  input  logic [NUM_CS-1:0]      cs_hit,
  input  logic [NUM_DRAM-1:0]    dram_hit,
  input  win_cfg_t [NUM_CS-1:0]  cfg,
  output acc_kind_e              kind,
  output logic [NUM_CS-1:0]      cs_drv,
  output logic [NUM_DRAM-1:0]    dram_drv,
  output port_sz_e               psz,
  output logic                   binh,
  output logic                   eterm,
  output logic                   undef
);

  localparam int CC_W = $clog2(NUM_CS + 1);
  localparam int DC_W = $clog2(NUM_DRAM + 1);

  logic [CC_W-1:0] n_cs;
  logic [DC_W-1:0] n_dr;
  win_cfg_t        sel_cfg;

  always_comb begin
    n_cs    = '0;
    sel_cfg = '0;
    for (int i = 0; i < NUM_CS; i++) begin
      n_cs = n_cs + CC_W'(cs_hit[i]);
      if (cs_hit[i]) sel_cfg = cfg[i];
    end
  end

  always_comb begin
    n_dr = '0;
    for (int j = 0; j < NUM_DRAM; j++) n_dr = n_dr + DC_W'(dram_hit[j]);
  end

  always_comb begin
    kind     = ACC_EXT;
    cs_drv   = '0;
    dram_drv = '0;
    psz      = PS_32;
    binh     = 1'b1;
    eterm    = 1'b1;
    undef    = 1'b0;
    if (n_dr != '0 && (n_dr > DC_W'(1) || n_cs != '0)) begin
      kind  = ACC_UNDEF;
      undef = 1'b1;
    end else if (n_dr == DC_W'(1)) begin
      kind     = ACC_DRAM;
      dram_drv = dram_hit;
      binh     = 1'b0;
      eterm    = 1'b0;
    end else if (n_cs > CC_W'(1)) begin
      kind   = ACC_MULTI;
      cs_drv = cs_hit;
    end else if (n_cs == CC_W'(1)) begin
      kind   = ACC_CS;
      cs_drv = cs_hit;
      psz    = ps_decode(sel_cfg.ps_code);
      binh   = !sel_cfg.burst_en;
      eterm  = 1'b0;
    end
  end

endmodule

// File: rtl/csdec_top.sv
module csdec_top
  import csdec_pkg::*;
#(
  parameter int NUM_CS   = 7,
  parameter int NUM_DRAM = 2,
  parameter int ADDR_W   = 32,
  parameter int IDX_W    = $clog2(NUM_CS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_we,
  input  logic [IDX_W-1:0]    reg_idx,
  input  logic [1:0]          reg_field,
  input  logic [CMP_W:0]      reg_wdata,
  input  logic                cyc_start,
  input  logic                cyc_end,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [NUM_DRAM-1:0] dram_hit,
  output logic [NUM_CS-1:0]   cs_n,
  output logic [NUM_DRAM-1:0] dram_sel,
  output logic [1:0]          port_size,
  output logic                burst_inh,
  output logic                ext_term,
  output logic                undef_acc
);

  localparam int LOW_W = ADDR_W - CMP_W;

  win_cfg_t [NUM_CS-1:0] cfg;
  logic                  boot_global;
  logic [CMP_W-1:0]      a_hi;
  logic                  unused_low;
  logic [NUM_CS-1:0]     cs_hit;

  acc_kind_e             kind;
  logic [NUM_CS-1:0]     cs_drv;
  logic [NUM_DRAM-1:0]   dram_drv;
  port_sz_e              psz;
  logic                  binh, eterm, undef;

  assign a_hi       = addr[ADDR_W-1 -: CMP_W];
  assign unused_low = ^addr[LOW_W-1:0];

  csdec_regs #(.NUM_CS(NUM_CS), .IDX_W(IDX_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_we     (reg_we),
    .reg_idx    (reg_idx),
    .reg_field  (reg_field),
    .reg_wdata  (reg_wdata),
    .cfg        (cfg),
    .boot_global(boot_global)
  );

  for (genvar i = 0; i < NUM_CS; i++) begin : g_cmp
    if (i == 0) begin : g_boot
      csdec_window u_win (
        .a_hi     (a_hi),
        .cfg      (cfg[i]),
        .force_hit(boot_global),
        .hit      (cs_hit[i])
      );
    end else begin : g_plain
      csdec_window u_win (
        .a_hi     (a_hi),
        .cfg      (cfg[i]),
        .force_hit(1'b0),
        .hit      (cs_hit[i])
      );
    end
  end

  csdec_resolve #(.NUM_CS(NUM_CS), .NUM_DRAM(NUM_DRAM)) u_res (
    .cs_hit  (cs_hit),
    .dram_hit(dram_hit),
    .cfg     (cfg),
    .kind    (kind),
    .cs_drv  (cs_drv),
    .dram_drv(dram_drv),
    .psz     (psz),
    .binh    (binh),
    .eterm   (eterm),
    .undef   (undef)
  );

  always_ff @(posedge clk) begin
    if (!rst_n || (cyc_end && !cyc_start)) begin
      cs_n      <= '1;
      dram_sel  <= '0;
      port_size <= PS_32;
      burst_inh <= 1'b0;
      ext_term  <= 1'b0;
      undef_acc <= 1'b0;
    end else if (cyc_start) begin
      cs_n      <= ~cs_drv;
      dram_sel  <= dram_drv;
      port_size <= psz;
      burst_inh <= binh;
      ext_term  <= eterm;
      undef_acc <= undef;
    end
  end

  p_none_ext_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_start && kind == ACC_EXT) |=>
      (&cs_n && dram_sel == '0 && port_size == PS_32 && burst_inh && ext_term));

  p_multi_forced_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(~cs_n) > 1) |-> (port_size == PS_32 && burst_inh && ext_term));

  p_dram_alone_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (|dram_sel) |-> (&cs_n && !undef_acc && $onehot0(dram_sel)));

  p_undef_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    undef_acc |-> (&cs_n && dram_sel == '0 && burst_inh && ext_term));

  p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_end && !cyc_start) |=> (&cs_n && dram_sel == '0 && !undef_acc));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!cyc_start && !cyc_end) |=> ($stable(cs_n) && $stable(port_size)));

endmodule

// File: tb/sim_csdec_top.sv
module sim_csdec_top;

  localparam int CLK_PERIOD = 10;
  localparam int NCS = 7;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_idx = '0;
  logic [1:0]  reg_field = '0;
  logic [16:0] reg_wdata = '0;
  logic        cyc_start = 1'b0;
  logic        cyc_end = 1'b0;
  logic [31:0] addr = '0;
  logic [1:0]  dram_hit = '0;
  logic [6:0]  cs_n;
  logic [1:0]  dram_sel;
  logic [1:0]  port_size;
  logic        burst_inh, ext_term, undef_acc;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  logic [15:0] m_base [NCS];
  logic [15:0] m_mask [NCS];
  logic        m_valid[NCS];
  logic [1:0]  m_ps   [NCS];
  logic        m_be   [NCS];
  logic        m_boot;

  always #(CLK_PERIOD/2) clk = ~clk;

  csdec_top u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_idx(reg_idx),
    .reg_field(reg_field), .reg_wdata(reg_wdata), .cyc_start(cyc_start),
    .cyc_end(cyc_end), .addr(addr), .dram_hit(dram_hit), .cs_n(cs_n),
    .dram_sel(dram_sel), .port_size(port_size), .burst_inh(burst_inh),
    .ext_term(ext_term), .undef_acc(undef_acc)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h addr=%h dram=%b",
               req, what, act, exp, addr, dram_hit);
    end
  endtask

  task automatic wr(input int idx, input int fld, input logic [16:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_idx = 3'(idx); reg_field = 2'(fld); reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
    case (fld)
      0: m_base[idx] = d[15:0];
      1: begin
        m_mask[idx] = d[15:0]; m_valid[idx] = d[16];
        if (idx == 0 && d[16]) m_boot = 1'b0;
      end
      2: begin m_ps[idx] = d[1:0]; m_be[idx] = d[2]; end
      default: ;
    endcase
  endtask

  // Independent model of the requirements.
  task automatic calc(input logic [15:0] a, input logic [1:0] dh,
                      output logic [6:0] e_csn, output logic [1:0] e_ds,
                      output logic [1:0] e_ps, output logic e_bi,
                      output logic e_et, output logic e_un, output string req);
    logic [6:0] hv;
    int nc, nd, who;
    hv = '0; nc = 0; who = 0;
    for (int i = 0; i < NCS; i++) begin
      hv[i] = m_valid[i] && ((~(a ^ m_base[i]) | m_mask[i]) == 16'hFFFF);
      if (i == 0 && m_boot) hv[i] = 1'b1;
      if (hv[i]) begin nc++; who = i; end
    end
    nd = int'(dh[0]) + int'(dh[1]);
    e_csn = 7'h7F; e_ds = 2'b00; e_ps = 2'b00; e_bi = 1'b1; e_et = 1'b1; e_un = 1'b0;
    if (nd > 0 && (nd > 1 || nc > 0)) begin
      e_un = 1'b1; req = "R6";
    end else if (nd == 1) begin
      e_ds = dh; e_bi = 1'b0; e_et = 1'b0; req = "R5";
    end else if (nc == 0) begin
      req = "R1,R2";
    end else if (nc > 1) begin
      e_csn = ~hv; req = "R1,R4";
    end else begin
      e_csn = ~hv;
      e_ps  = (m_ps[who] == 2'b00) ? 2'b00 : (m_ps[who] == 2'b01) ? 2'b01 : 2'b10;
      e_bi  = !m_be[who];
      e_et  = 1'b0;
      req   = (who == 0 && m_boot) ? "R7" : "R1,R3";
    end
  endtask

  task automatic check_out(input logic [15:0] a, input logic [1:0] dh, input string tag);
    logic [6:0] ec; logic [1:0] ed, ep; logic eb, ee, eu; string rq;
    calc(a, dh, ec, ed, ep, eb, ee, eu, rq);
    rq = {rq, tag};
    chk(rq, "cs_n", 32'(cs_n), 32'(ec));
    chk(rq, "dram_sel", 32'(dram_sel), 32'(ed));
    chk(rq, "port_size", 32'(port_size), 32'(ep));
    chk(rq, "burst_inh", 32'(burst_inh), 32'(eb));
    chk(rq, "ext_term", 32'(ext_term), 32'(ee));
    chk(rq, "undef_acc", 32'(undef_acc), 32'(eu));
  endtask

  task automatic check_idle(input string req);
    chk(req, "idle cs_n", 32'(cs_n), 32'h7F);
    chk(req, "idle dram_sel", 32'(dram_sel), 0);
    chk(req, "idle port_size", 32'(port_size), 0);
    chk(req, "idle flags", 32'({burst_inh, ext_term, undef_acc}), 0);
  endtask

  task automatic one_cycle(input logic [15:0] a, input logic [1:0] dh, input string tag);
    @(negedge clk);
    addr = {a, 16'hA5C3}; dram_hit = dh; cyc_start = 1'b1;
    @(negedge clk);
    cyc_start = 1'b0;
    check_out(a, dh, tag);
    cyc_end = 1'b1;
    @(negedge clk);
    cyc_end = 1'b0;
    check_idle("R8");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NCS; i++) begin
      m_base[i] = '0; m_mask[i] = '0; m_valid[i] = 1'b0; m_ps[i] = '0; m_be[i] = 1'b0;
    end
    m_boot = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_idle("R10");

    // Boot mode: window 0 answers everywhere (R7).
    one_cycle(16'h1234, 2'b00, "");
    one_cycle(16'hFFFF, 2'b00, "");
    one_cycle(16'h0000, 2'b01, "");
    wr(0, 0, 17'h00000);
    wr(0, 1, {1'b0, 16'h00FF});
    one_cycle(16'h7777, 2'b00, " valid0 mask write keeps boot");
    wr(0, 2, 17'h00005);
    wr(0, 1, {1'b1, 16'h00FF});
    one_cycle(16'h7777, 2'b00, " boot ended");

    // Window set-up (R9 layout).
    wr(1, 0, 17'h00100); wr(1, 1, {1'b1, 16'h00FF}); wr(1, 2, 17'h00002);
    wr(2, 0, 17'h00180); wr(2, 1, {1'b1, 16'h007F}); wr(2, 2, 17'h00004);
    wr(3, 0, 17'h00200); wr(3, 1, {1'b1, 16'h01FF}); wr(3, 2, 17'h00007);
    wr(4, 0, 17'h00300); wr(4, 1, {1'b1, 16'h00FF}); wr(4, 2, 17'h00001);
    wr(5, 0, 17'h00500); wr(5, 1, {1'b1, 16'h000F}); wr(5, 2, 17'h00006);
    wr(6, 0, 17'h00600); wr(6, 1, {1'b0, 16'h00FF}); wr(6, 2, 17'h00002);

    for (int k = 0; k < 256; k++)
      for (int d = 0; d < 4; d++)
        one_cycle(16'(k * 8), 2'(d), "");

    one_cycle(16'h8100, 2'b00, " high bit");
    one_cycle(16'hFF00, 2'b00, " high bit");
    one_cycle(16'h4508, 2'b00, " high bit");

    // R9: moving window 5 base moves its hit.
    wr(5, 0, 17'h00700);
    one_cycle(16'h0708, 2'b00, " R9 moved base");
    one_cycle(16'h0508, 2'b00, " R9 old base");

    // R8 hold: new address without start leaves outputs alone.
    @(negedge clk);
    addr = {16'h0140, 16'h0}; dram_hit = 2'b00; cyc_start = 1'b1;
    @(negedge clk);
    cyc_start = 1'b0; addr = {16'h0705, 16'h0}; dram_hit = 2'b01;
    @(negedge clk);
    dram_hit = 2'b00;
    check_out(16'h0140, 2'b00, " R8 hold");

    // R8 start wins over end in the same cycle.
    @(negedge clk);
    addr = {16'h0705, 16'h0}; cyc_start = 1'b1; cyc_end = 1'b1;
    @(negedge clk);
    cyc_start = 1'b0; cyc_end = 1'b0;
    check_out(16'h0705, 2'b00, " R8 start over end");
    @(negedge clk);
    cyc_end = 1'b1;
    @(negedge clk);
    cyc_end = 1'b0;
    check_idle("R8");

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule